// File: doc/BRIEF.md
# Bus-to-device transfer handshake controller

This block sequences one data transfer between a shared bus and a local device by interlocking two four-phase handshakes. The bus side offers a read request and a write request and receives a transfer acknowledge. The device side receives a local request and answers with a local acknowledge. Between the two, the block drives the enable of the data transceiver that connects the device data lines to the bus. The enable is only open while data should flow.

All three inputs are asynchronous to the controller clock. Each input passes through a synchroniser chain before the sequencer sees it. Outputs come from registers. A transfer runs as a fixed chain of events, and every output returns low before another request is accepted. A request that names both directions at once while the block is idle is refused. In that case the block stays idle and raises an error flag, which holds until reset.

Top module: `bus_xfer_ctrl`

## Requirements
- R1: While `rst` is high, and at the first clock edge after it is asserted, `bus_ack_o`, `xcvr_en_o`, `loc_req_o` and `conflict_o` are low. This holds even when reset arrives in the middle of a transfer.
- R2: The controller is idle and `rd_req_i` rises alone. On the third rising clock edge after the change, `loc_req_o` goes high, and `xcvr_en_o` and `bus_ack_o` stay low. With the default of two synchroniser stages, any input change takes effect on the third edge.
- R3: In a read, `xcvr_en_o` rises only after the synchronised `loc_ack_i` is high. `bus_ack_o` rises one edge after `xcvr_en_o`. `bus_ack_o` never rises unless `xcvr_en_o` and `loc_req_o` are high.
- R4: In a read, all three outputs stay high until `rd_req_i` falls. After it falls, `xcvr_en_o` drops first while `bus_ack_o` and `loc_req_o` stay high. On the next edge, `bus_ack_o` and `loc_req_o` drop together.
- R5: In a write, the rise of `wr_req_i` opens `xcvr_en_o` first. `loc_req_o` follows one edge later. `bus_ack_o` rises once `loc_ack_i` is seen high.
- R6: A write is released the same way as a read, triggered by the fall of `wr_req_i`. First the outputs become {ack=1, xcvr=0, req=1}, then all three go low.
- R7: After a release, no new transfer starts until `loc_ack_i` is seen low. A request waiting at that point starts one edge after the idle state is reached.
- R8: Both requests are high in the idle state. The outputs stay low and `conflict_o` goes high. `conflict_o` stays high through later transfers until reset.
- R9: The request of the opposite direction has no effect on the outputs while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req_i | input | 1 | Bus read request, asynchronous |
| wr_req_i | input | 1 | Bus write request, asynchronous |
| loc_ack_i | input | 1 | Device acknowledge, asynchronous |
| bus_ack_o | output | 1 | Transfer acknowledge to the bus |
| xcvr_en_o | output | 1 | Data transceiver enable |
| loc_req_o | output | 1 | Request to the device |
| conflict_o | output | 1 | Sticky flag for simultaneous read and write requests |

## Verification
The bench counts edges from each input change and samples both the edge where an output should move and the edge before it. A controller that acknowledged before opening the transceiver would show up at that earlier sample. So would one that reordered the release, or dropped all outputs at once. The bench holds the device acknowledge high after a release while a new request waits. A design that skipped that wait would restart the transfer early. Further checks cover:
- both requests arriving together, where a design that started a transfer or let the flag clear would be caught;
- the opposite request arriving during a transfer, where a design that changed mode would be caught;
- reset in the middle of a transfer.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_R_REQ  = 4'd1,
    ST_R_OPEN = 4'd2,
    ST_R_ACK  = 4'd3,
    ST_W_OPEN = 4'd4,
    ST_W_REQ  = 4'd5,
    ST_W_ACK  = 4'd6,
    ST_DROP   = 4'd7,
    ST_REL    = 4'd8
  } xfer_state_t;

  typedef struct packed {
    logic ack;
    logic xcvr;
    logic req;
  } drive_t;

  function automatic drive_t drive_of(xfer_state_t s);
    drive_t d;
    d = '0;
    case (s)
      ST_R_REQ:  d = '{ack: 1'b0, xcvr: 1'b0, req: 1'b1};
      ST_R_OPEN: d = '{ack: 1'b0, xcvr: 1'b1, req: 1'b1};
      ST_R_ACK:  d = '{ack: 1'b1, xcvr: 1'b1, req: 1'b1};
      ST_W_OPEN: d = '{ack: 1'b0, xcvr: 1'b1, req: 1'b0};
      ST_W_REQ:  d = '{ack: 1'b0, xcvr: 1'b1, req: 1'b1};
      ST_W_ACK:  d = '{ack: 1'b1, xcvr: 1'b1, req: 1'b1};
      ST_DROP:   d = '{ack: 1'b1, xcvr: 1'b0, req: 1'b1};
      default:   d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/xfer_sync.sv
module xfer_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import xfer_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        rd_s,
  input  logic        wr_s,
  input  logic        ack_s,
  output xfer_state_t state_nxt,
  output logic        clash
);
  xfer_state_t state_q;

  always_comb begin
    state_nxt = state_q;
    clash     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (rd_s && wr_s) clash = 1'b1;
        else if (rd_s)    state_nxt = ST_R_REQ;
        else if (wr_s)    state_nxt = ST_W_OPEN;
      end
      ST_R_REQ:  if (ack_s) state_nxt = ST_R_OPEN;
      ST_R_OPEN: state_nxt = ST_R_ACK;
      ST_R_ACK:  if (!rd_s) state_nxt = ST_DROP;
      ST_W_OPEN: state_nxt = ST_W_REQ;
      ST_W_REQ:  if (ack_s) state_nxt = ST_W_ACK;
      ST_W_ACK:  if (!wr_s) state_nxt = ST_DROP;
      ST_DROP:   state_nxt = ST_REL;
      ST_REL:    if (!ack_s) state_nxt = ST_IDLE;
      default:   state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_nxt;
  end
endmodule

// File: rtl/xfer_outreg.sv
module xfer_outreg
  import xfer_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  xfer_state_t state_nxt,
  input  logic        clash,
  output drive_t      drive_q,
  output logic        err_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      drive_q <= '0;
      err_q   <= 1'b0;
    end else begin
      drive_q <= drive_of(state_nxt);
      err_q   <= err_q | clash;
    end
  end
endmodule

// File: rtl/bus_xfer_ctrl.sv
module bus_xfer_ctrl
  import xfer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_req_i,
  input  logic wr_req_i,
  input  logic loc_ack_i,
  output logic bus_ack_o,
  output logic xcvr_en_o,
  output logic loc_req_o,
  output logic conflict_o
);
  localparam int NUM_IN = 3;

  logic [NUM_IN-1:0] raw_in, sync_in;
  xfer_state_t       state_nxt;
  logic              clash;
  drive_t            drive_q;

  assign raw_in = {loc_ack_i, wr_req_i, rd_req_i};

  xfer_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(raw_in), .sync_o(sync_in)
  );

  xfer_seq u_seq (
    .clk(clk), .rst(rst),
    .rd_s(sync_in[0]), .wr_s(sync_in[1]), .ack_s(sync_in[2]),
    .state_nxt(state_nxt), .clash(clash)
  );

  xfer_outreg u_out (
    .clk(clk), .rst(rst), .state_nxt(state_nxt), .clash(clash),
    .drive_q(drive_q), .err_q(conflict_o)
  );

  assign bus_ack_o = drive_q.ack;
  assign xcvr_en_o = drive_q.xcvr;
  assign loc_req_o = drive_q.req;
endmodule

// File: rtl/bus_xfer_ctrl_chk.sv
module bus_xfer_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic bus_ack_o,
  input logic xcvr_en_o,
  input logic loc_req_o,
  input logic conflict_o
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> !bus_ack_o && !xcvr_en_o && !loc_req_o && !conflict_o);

  assert_ack_after_open_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_ack_o) |-> xcvr_en_o && loc_req_o && $past(xcvr_en_o));

  assert_release_order_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_ack_o) |-> !xcvr_en_o && !loc_req_o && !$past(xcvr_en_o));

  assert_xcvr_before_req_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(loc_req_o) && xcvr_en_o) |-> $past(xcvr_en_o));

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    conflict_o |=> conflict_o);
endmodule

bind bus_xfer_ctrl bus_xfer_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .bus_ack_o(bus_ack_o), .xcvr_en_o(xcvr_en_o),
  .loc_req_o(loc_req_o), .conflict_o(conflict_o)
);

// File: tb/test_bus_xfer_ctrl.sv
`timescale 1ns/1ps
module test_bus_xfer_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd = 1'b0, wr = 1'b0, lack = 1'b0;
  logic bus_ack, xcvr_en, loc_req, conflict;
  logic exp_err = 1'b0;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bus_xfer_ctrl i_bus_xfer_ctrl (
    .clk(clk), .rst(rst), .rd_req_i(rd), .wr_req_i(wr), .loc_ack_i(lack),
    .bus_ack_o(bus_ack), .xcvr_en_o(xcvr_en), .loc_req_o(loc_req),
    .conflict_o(conflict)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // exp encoding: {ack, xcvr, req}
  task automatic chk(input logic [2:0] exp, input string req);
    logic [3:0] act, want;
    act  = {bus_ack, xcvr_en, loc_req, conflict};
    want = {exp, exp_err};
    total++;
    if (act !== want) begin
      bad++;
      $display("FAIL %s: {ack,xcvr,req,err} actual=%b expected=%b at %0t", req, act, want, $time);
    end
  endtask

  task automatic do_read(input int gap);
    rd = 1'b1;
    tick(2); chk(3'b000, "R2");
    tick(1); chk(3'b001, "R2");
    tick(gap); chk(3'b001, "R3");
    lack = 1'b1;
    tick(3); chk(3'b011, "R3");
    tick(1); chk(3'b111, "R3");
    tick(gap); chk(3'b111, "R4");
    rd = 1'b0;
    tick(3); chk(3'b101, "R4");
    tick(1); chk(3'b000, "R4");
    lack = 1'b0;
    tick(4); chk(3'b000, "R7");
  endtask

  task automatic do_write(input int gap);
    wr = 1'b1;
    tick(3); chk(3'b010, "R5");
    tick(1); chk(3'b011, "R5");
    tick(gap); chk(3'b011, "R5");
    lack = 1'b1;
    tick(3); chk(3'b111, "R5");
    tick(gap);
    wr = 1'b0;
    tick(3); chk(3'b101, "R6");
    tick(1); chk(3'b000, "R6");
    lack = 1'b0;
    tick(4); chk(3'b000, "R6");
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    chk(3'b000, "R1");
    tick(2);

    for (int g = 0; g < 4; g++) begin
      do_read(g);
      do_write(g);
    end

    // R7: after release, a waiting read starts only once loc_ack is low
    rd = 1'b1;
    tick(3); lack = 1'b1;
    tick(4); chk(3'b111, "R3");
    rd = 1'b0;
    tick(4); chk(3'b000, "R4");
    rd = 1'b1;
    tick(8); chk(3'b000, "R7");
    lack = 1'b0;
    tick(3); chk(3'b000, "R7");
    tick(1); chk(3'b001, "R7");
    lack = 1'b1;
    tick(4); chk(3'b111, "R3");

    // R9: write request during a read
    wr = 1'b1;
    tick(6); chk(3'b111, "R9");
    wr = 1'b0;
    tick(4); chk(3'b111, "R9");
    rd = 1'b0;
    tick(4); chk(3'b000, "R4");
    lack = 1'b0;
    tick(4);

    // R9: read request during a write
    wr = 1'b1;
    tick(4); chk(3'b011, "R5");
    rd = 1'b1;
    tick(6); chk(3'b011, "R9");
    rd = 1'b0;
    tick(4); chk(3'b011, "R9");
    lack = 1'b1;
    tick(3); chk(3'b111, "R5");
    wr = 1'b0;
    tick(4); chk(3'b000, "R6");
    lack = 1'b0;
    tick(4);

    // R8: both requests while idle
    rd = 1'b1; wr = 1'b1;
    tick(2); chk(3'b000, "R8");
    exp_err = 1'b1;
    tick(1); chk(3'b000, "R8");
    tick(5); chk(3'b000, "R8");
    rd = 1'b0; wr = 1'b0;
    tick(4); chk(3'b000, "R8");
    do_read(1);
    do_write(0);

    // R1: reset in the middle of a transfer clears everything
    rd = 1'b1;
    tick(3); lack = 1'b1;
    tick(4); chk(3'b111, "R3");
    rst = 1'b1; rd = 1'b0; lack = 1'b0;
    exp_err = 1'b0;
    tick(1); chk(3'b000, "R1");
    tick(2);
    rst = 1'b0;
    tick(4); chk(3'b000, "R1");
    do_read(2);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule